// File: doc/BRIEF.md
# Three-Port Register File

A clocked array of general-purpose registers with two read ports and one write port, sized to feed two source operands to an execution stage and accept one result in the same cycle. Each read port takes a register index and returns that register's word without waiting for a clock. The write port stores its data into the addressed register on the rising clock edge when its enable is high.

The array depth and the word width are parameters. A third parameter fixes what a read returns when, in the same cycle, the write port targets the register being read. In `OLD_VALUE` mode the read returns the contents from before the write. In `WRITE_THROUGH` mode the read returns the data being written. Each read port applies this rule on its own.

When the depth is not a power of two, some index values address no register. A write to such an index does nothing. A read from such an index returns zero.

Top module: `regfile_3p`

## Requirements
- R1: Both read ports and the write port operate in the same cycle with independent indices. Each read port returns the word held at its own index.
- R2: When `wr_en_i` is 1 at a rising edge of `clk_i`, the register at `wr_idx_i` takes the value of `wr_data_i`. No other register changes at that edge.
- R3: When `wr_en_i` is 0 at a rising edge, no register changes.
- R4: While `rst_ni` is 0, every register holds zero, whatever the clock does. The clear takes effect without waiting for a clock edge.
- R5: With `COLLIDE_MODE` = `OLD_VALUE` (value 0), a read at the index being written in that cycle returns the contents from before the write.
- R6: With `COLLIDE_MODE` = `WRITE_THROUGH` (value 1), a read at the index being written in that cycle returns `wr_data_i`.
- R7: The collision rule is applied separately on each read port. When both read indices equal the write index, both ports return the same collision result.
- R8: An index of `NUM_REGS` or higher addresses nothing. A write to it changes no register. A read from it returns zero.
- R9: A read is combinational. A change of a read index changes that port's data within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes take effect on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears every register |
| rd_a_idx_i | input | IDX_W | Register index for read port A |
| rd_a_data_o | output | DATA_W | Word returned by read port A |
| rd_b_idx_i | input | IDX_W | Register index for read port B |
| rd_b_data_o | output | DATA_W | Word returned by read port B |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | IDX_W | Register index for the write |
| wr_data_i | input | DATA_W | Data to be written |

## Verification
Two instances, one in each collision mode, receive identical stimulus. Their reads are compared with a reference array every cycle, so any difference between the two instances comes from the collision rule alone. The random traffic uses the full index range, which includes the unmapped indices above a 24-register depth. Some phases narrow the indices to a few registers so that write/read collisions on one or both ports happen often. Directed cases cover the following: a clean array after reset, a disabled write carrying data, a write to an unmapped index, a read index changed between clock edges, and a reset applied mid-run. Together they separate the storage, write enable, range check, bypass path and reset faults.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  typedef enum logic [0:0] {
    OLD_VALUE     = 1'b0,
    WRITE_THROUGH = 1'b1
  } collide_mode_e;
endpackage

// File: rtl/regfile_wdec.sv
module regfile_wdec #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  output logic [NUM_REGS-1:0] sel_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel_o[k] = wr_en_i && (32'(wr_idx_i) == k);
  end

  // R2
  wdec_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  // R3
  wdec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (sel_o == '0));
endmodule

// File: rtl/regfile_store.sv
module regfile_store #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              sel_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[k] <= '0;
      else if (sel_i[k]) q_o[k] <= wr_data_i;
    end

    // R2
    store_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i[k] |=> (q_o[k] == $past(wr_data_i)));

    // R3
    store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i[k] |=> $stable(q_o[k]));

    // R4
    store_clear_chk: assert property (@(posedge clk_i)
      !rst_ni |-> (q_o[k] == '0));
  end
endmodule

// File: rtl/regfile_rport.sv
module regfile_rport
  import regfile_pkg::*;
#(
  parameter int            NUM_REGS     = 32,
  parameter int            DATA_W       = 32,
  parameter collide_mode_e COLLIDE_MODE = OLD_VALUE,
  parameter int            IDX_W        = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] q_i,
  input  logic [IDX_W-1:0]                rd_idx_i,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output logic [DATA_W-1:0]               rd_data_o
);
  logic in_range;
  logic [DATA_W-1:0] stored;

  assign in_range = 32'(rd_idx_i) < NUM_REGS;

  always_comb begin
    stored = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (32'(rd_idx_i) == k) stored = q_i[k];
  end

  if (COLLIDE_MODE == WRITE_THROUGH) begin : g_bypass
    logic hit;
    assign hit       = wr_en_i && in_range && (wr_idx_i == rd_idx_i);
    assign rd_data_o = hit ? wr_data_i : stored;
  end else begin : g_plain
    assign rd_data_o = stored;
  end
endmodule

// File: rtl/regfile_3p.sv
module regfile_3p
  import regfile_pkg::*;
#(
  parameter int            NUM_REGS     = 32,
  parameter int            DATA_W       = 32,
  parameter collide_mode_e COLLIDE_MODE = OLD_VALUE,
  parameter int            IDX_W        = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:0]             sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] q;
  logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  assign rd_idx[0]   = rd_a_idx_i;
  assign rd_idx[1]   = rd_b_idx_i;
  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  regfile_wdec #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_wdec (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .sel_o(sel)
  );

  regfile_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .sel_i(sel), .wr_data_i, .q_o(q)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic collide;
    logic mapped;
    assign mapped  = 32'(rd_idx[p]) < NUM_REGS;
    assign collide = wr_en_i && mapped && (wr_idx_i == rd_idx[p]);

    regfile_rport #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
      .COLLIDE_MODE(COLLIDE_MODE), .IDX_W(IDX_W)
    ) u_rport (
      .q_i(q), .rd_idx_i(rd_idx[p]), .wr_en_i, .wr_idx_i, .wr_data_i,
      .rd_data_o(rd_data[p])
    );

    if (COLLIDE_MODE == OLD_VALUE) begin : g_old_chk
      // R5
      rd_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        collide |-> (rd_data[p] == q[rd_idx[p]]));
    end else begin : g_wt_chk
      // R6
      rd_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        collide |-> (rd_data[p] == wr_data_i));
    end

    // R8
    rd_unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mapped |-> (rd_data[p] == '0));
  end

  // R7
  rd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o));
endmodule

// File: tb/regfile_3p_bench.sv
module regfile_3p_bench;
  import regfile_pkg::*;

  localparam int NREG  = 24;
  localparam int DW    = 16;
  localparam int IW    = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] ra, rb, wi;
  logic          we;
  logic [DW-1:0] wd;
  logic [DW-1:0] a_old, b_old, a_wt, b_wt;

  logic [DW-1:0] model [NREG];
  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  regfile_3p #(.NUM_REGS(NREG), .DATA_W(DW), .COLLIDE_MODE(OLD_VALUE)) u_regfile_3p (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(ra), .rd_a_data_o(a_old),
    .rd_b_idx_i(rb), .rd_b_data_o(b_old),
    .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd)
  );

  regfile_3p #(.NUM_REGS(NREG), .DATA_W(DW), .COLLIDE_MODE(WRITE_THROUGH)) u_regfile_3p_wt (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(ra), .rd_a_data_o(a_wt),
    .rd_b_idx_i(rb), .rd_b_data_o(b_wt),
    .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd)
  );

  function automatic logic [DW-1:0] exp_rd(logic [IW-1:0] idx, bit thru);
    if (int'(idx) >= NREG) return '0;
    if (thru && we && wi == idx) return wd;
    return model[idx];
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (ra=%0d rb=%0d we=%0b wi=%0d)",
               req, act, exp, ra, rb, we, wi);
    end
  endtask

  task automatic check_reads(string req);
    check({req, " old A"}, a_old, exp_rd(ra, 0));
    check({req, " old B"}, b_old, exp_rd(rb, 0));
    check({req, " thru A"}, a_wt, exp_rd(ra, 1));
    check({req, " thru B"}, b_wt, exp_rd(rb, 1));
  endtask

  // drive at negedge, check mid-low phase, commit model at posedge
  task automatic cycle(logic [IW-1:0] a, logic [IW-1:0] b, logic e,
                       logic [IW-1:0] w, logic [DW-1:0] d, string req);
    @(negedge clk);
    ra = a; rb = b; we = e; wi = w; wd = d;
    #1;
    check_reads(req);
    @(posedge clk);
    if (rst_n && e && int'(w) < NREG) model[w] = d;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    ra = '0; rb = '0; we = 0; wi = '0; wd = '0;
    for (int k = 0; k < NREG; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R4: reset contents all zero
    for (int k = 0; k < NREG; k++) begin
      ra = IW'(k); rb = IW'(NREG - 1 - k); #1;
      check_reads("R4 reset");
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R1: fill all registers, read back two at once
    for (int k = 0; k < NREG; k++)
      cycle('0, '0, 1'b1, IW'(k), DW'(16'h1000 + k * 7), "R2 fill");
    for (int k = 0; k < NREG; k++)
      cycle(IW'(k), IW'((k + 5) % NREG), 1'b0, '0, '0, "R1 dual read");

    // R3: disabled write carrying data
    cycle(IW'(3), IW'(4), 1'b0, IW'(3), 16'hdead, "R3 disabled");
    cycle(IW'(3), IW'(4), 1'b0, '0, '0, "R3 after disabled");

    // R5 R6 R7: collisions on one and both ports
    cycle(IW'(7), IW'(9), 1'b1, IW'(7), 16'hbeef, "R5 R6 collide A");
    cycle(IW'(7), IW'(9), 1'b1, IW'(9), 16'hcafe, "R5 R6 collide B");
    cycle(IW'(11), IW'(11), 1'b1, IW'(11), 16'h1234, "R7 both ports");
    cycle(IW'(11), IW'(11), 1'b0, '0, '0, "R7 after");

    // R8: unmapped index write and read
    cycle(IW'(NREG), IW'(31), 1'b1, IW'(NREG + 2), 16'hffff, "R8 unmapped");
    cycle(IW'(NREG), IW'(31), 1'b1, IW'(31), 16'h7777, "R8 unmapped collide");
    for (int k = 0; k < NREG; k++)
      cycle(IW'(k), IW'(k), 1'b0, '0, '0, "R8 no alias");

    // R9: read index changes between edges
    @(negedge clk);
    we = 0; ra = IW'(2); rb = IW'(5); #1;
    check_reads("R9 comb first");
    ra = IW'(6); rb = IW'(1); #1;
    check_reads("R9 comb second");

    // random traffic, wide and narrow index ranges
    for (int n = 0; n < 3000; n++) begin
      logic [IW-1:0] a, b, w;
      if (n % 3 == 0) begin
        a = IW'($urandom_range(0, 3)); b = IW'($urandom_range(0, 3));
        w = IW'($urandom_range(0, 3));
      end else begin
        a = IW'($urandom); b = IW'($urandom); w = IW'($urandom);
      end
      cycle(a, b, 1'($urandom), w, DW'($urandom), "R1 R5 R6 random");
    end

    // R4: mid-run asynchronous reset
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    for (int k = 0; k < NREG; k++) model[k] = '0;
    for (int k = 0; k < NREG; k++) begin
      ra = IW'(k); rb = IW'(k); we = 0; #1;
      check_reads("R4 async clear");
    end
    @(negedge clk);
    rst_n = 1'b1;
    cycle(IW'(0), IW'(1), 1'b1, IW'(1), 16'h0abc, "R4 R6 after reset");
    cycle(IW'(0), IW'(1), 1'b0, '0, '0, "R2 after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule